// File: doc/BRIEF.md
# Trigger Busy Gate with Auto-Clear

This block sits in front of a downstream trigger fan-out. It merges three kinds of trigger request into one raw request: external inputs that are individually enabled, an internal periodic generator, and a software command. A rising edge of that raw request passes out as a one-clock trigger pulse only when the busy latch is clear. The same pulse sets the latch, and the latch then holds back every later request until something clears it.

Software clears the latch by writing zero to the control register. When the timeout enable is set, a programmable delay clears the latch without software action. A force-busy bit sets the latch directly, which produces a trigger if the latch was clear. While force-busy is set, every clear path is blocked. A 32-bit counter records the triggers sent. All state is reached through a simple write/read strobe bus, and a read returns its data one clock after the strobe.

Top module: `trig_busy_gate`

## Requirements
- R1: A rising edge of the raw request while the latch is clear produces `trig_out` high for exactly one clock, in the cycle after the edge is sampled. The latch (`busy_out`) is set in that same cycle.
- R2: The raw request is the OR of three sources:
  - external input i, ANDed with bit i of the source-enable register (address 0);
  - the periodic generator, enabled by bit 31 of address 0;
  - a write of bit 0 = 1 to the command register (address 5).
- R3: Requests that arrive while the latch is set are dropped, not stored. After a clear, no trigger appears until a new rising edge of the raw request.
- R4: A write to the control register (address 1) with bit 0 = 0 and bit 1 = 0 clears the latch when force-busy is not set. A write with bit 0 = 1 leaves the latch unchanged.
- R5: With the timeout enable (control bit 2) set, the latch clears DELAY clocks after the trigger that set it. DELAY is held at address 3, and a value of 0 acts as 1. A write to address 3 restarts the delay.
- R6: Setting force-busy (control bit 1) while the latch is clear produces exactly one trigger. While force-busy is set, neither software writes nor the timeout clear the latch.
- R7: With its enable set and PERIOD (address 2) at 2 or more, the periodic generator issues one request every PERIOD clocks. With its enable clear, it issues none.
- R8: A 32-bit counter (address 4) counts each trigger sent. Any write to address 4 resets it to zero.
- R9: A synchronous reset clears the latch, force-busy, all enables, the timers and the counter. After reset, `trig_out` and `busy_out` are low.
- R10: `rd_stb` with `rd_addr` returns the register content on `rd_data` one clock later. Control reads as {timeout enable, force-busy, latch} in bits 2..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_trig | input | NUM_EXT | External trigger inputs, already synchronised |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid one clock after the strobe |
| trig_out | output | 1 | One-clock trigger pulse to downstream |
| busy_out | output | 1 | Busy latch state |

## Verification
The bench holds a request high or pulses it while the latch is set, then clears the latch. A design that queued requests or detected levels would emit a trigger straight after the clear. The timeout is measured to the exact clock, including after a delay rewrite in mid-count; an off-by-one or a missed restart would move the falling edge of `busy_out`. Force-busy is checked both for its single trigger and for blocking the software clear and the timeout clear. A design that let either path through would drop the latch early. The period of the generator is measured between two trigger pulses, which exposes an off-by-one reload.

// File: rtl/trig_busy_pkg.sv
package trig_busy_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_SRC   = 3'd0,
    REG_CTRL  = 3'd1,
    REG_OSC   = 3'd2,
    REG_DELAY = 3'd3,
    REG_COUNT = 3'd4,
    REG_CMD   = 3'd5
  } reg_addr_e;

  localparam int CTRL_BUSY  = 0;
  localparam int CTRL_FORCE = 1;
  localparam int CTRL_TMO   = 2;
  localparam int SRC_OSC    = 31;
endpackage

// File: rtl/tbg_osc.sv
module tbg_osc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] period,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic         last;

  assign last = (cnt == period - W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + W'(1);
      tick <= 1'b0;
    end
  end

  // R7: a disabled generator issues nothing
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick);
endmodule

// File: rtl/tbg_timer.sv
module tbg_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         busy,
  input  logic         restart,
  input  logic [W-1:0] delay,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = en && busy &&
                  (({1'b0, cnt} + (W+1)'(1)) >= {1'b0, delay});

  always_ff @(posedge clk) begin
    if (rst || restart || !busy)
      cnt <= '0;
    else if (en && !expire)
      cnt <= cnt + W'(1);
  end

  // R5: the count saturates once the delay has elapsed
  a_r5_saturate: assert property (@(posedge clk) disable iff (rst || restart)
    (expire && busy) |=> $stable(cnt) || !busy);
endmodule

// File: rtl/tbg_counter.sv
module tbg_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      value <= '0;
    else if (inc)
      value <= value + W'(1);
  end

  // R8: each counted trigger adds exactly one
  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> value == $past(value) + W'(1));
  // R8: a write resets the count
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> value == '0);
endmodule

// File: rtl/trig_busy_gate.sv
module trig_busy_gate
  import trig_busy_pkg::*;
#(
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] ext_trig,
  input  logic               wr_stb,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_stb,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               trig_out,
  output logic               busy_out
);
  logic [NUM_EXT-1:0] ext_en;
  logic               osc_en;
  logic               force_q;
  logic               tmo_en;
  logic               busy_q;
  logic [DATA_W-1:0]  osc_period;
  logic [DATA_W-1:0]  delay;
  logic [DATA_W-1:0]  count;
  logic               osc_tick;
  logic               expire;
  logic               raw, raw_q, fire;
  logic               wr_src, wr_ctrl, wr_osc, wr_delay, wr_count, cmd_req;
  logic               sw_clr;

  assign wr_src   = wr_stb && (wr_addr == REG_SRC);
  assign wr_ctrl  = wr_stb && (wr_addr == REG_CTRL);
  assign wr_osc   = wr_stb && (wr_addr == REG_OSC);
  assign wr_delay = wr_stb && (wr_addr == REG_DELAY);
  assign wr_count = wr_stb && (wr_addr == REG_COUNT);
  assign cmd_req  = wr_stb && (wr_addr == REG_CMD) && wr_data[0];

  assign raw    = (|(ext_trig & ext_en)) | osc_tick | cmd_req | force_q;
  assign fire   = raw && !raw_q && !busy_q;
  assign sw_clr = wr_ctrl && !wr_data[CTRL_BUSY] && !wr_data[CTRL_FORCE] && !force_q;

  tbg_osc #(.W(DATA_W)) u_osc (
    .clk(clk), .rst(rst), .en(osc_en), .restart(wr_osc),
    .period(osc_period), .tick(osc_tick));

  tbg_timer #(.W(DATA_W)) u_timer (
    .clk(clk), .rst(rst), .en(tmo_en), .busy(busy_q),
    .restart(wr_delay || fire), .delay(delay), .expire(expire));

  tbg_counter #(.W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .inc(fire), .clr(wr_count), .value(count));

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_en     <= '0;
      osc_en     <= 1'b0;
      force_q    <= 1'b0;
      tmo_en     <= 1'b0;
      osc_period <= '0;
      delay      <= '0;
    end else begin
      if (wr_src) begin
        ext_en <= wr_data[NUM_EXT-1:0];
        osc_en <= wr_data[SRC_OSC];
      end
      if (wr_ctrl) begin
        force_q <= wr_data[CTRL_FORCE];
        tmo_en  <= wr_data[CTRL_TMO];
      end
      if (wr_osc)   osc_period <= wr_data;
      if (wr_delay) delay      <= wr_data;
    end
  end

  // busy latch and trigger pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      raw_q    <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      raw_q    <= raw;
      trig_out <= fire;
      if (fire)
        busy_q <= 1'b1;
      else if (!force_q && (sw_clr || expire))
        busy_q <= 1'b0;
    end
  end

  assign busy_out = busy_q;

  // read port
  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_stb) begin
      rd_data <= '0;
      case (rd_addr)
        REG_SRC: begin
          rd_data[NUM_EXT-1:0] <= ext_en;
          rd_data[SRC_OSC]     <= osc_en;
        end
        REG_CTRL: begin
          rd_data[CTRL_BUSY]  <= busy_q;
          rd_data[CTRL_FORCE] <= force_q;
          rd_data[CTRL_TMO]   <= tmo_en;
        end
        REG_OSC:   rd_data <= osc_period;
        REG_DELAY: rd_data <= delay;
        REG_COUNT: rd_data <= count;
        default:   rd_data <= '0;
      endcase
    end
  end

  // R1: a trigger pulse comes with the latch set
  a_r1_sets_busy: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> busy_q);
  // R1: the pulse lasts one clock
  a_r1_one_clock: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out);
  // R3: no trigger while the latch is held
  a_r3_blocked: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !trig_out);
  // R6: force-busy keeps the latch set
  a_r6_force_holds: assert property (@(posedge clk) disable iff (rst)
    (force_q && busy_q) |=> busy_q);
  // R4: a clearing write drops the latch
  a_r4_sw_clear: assert property (@(posedge clk) disable iff (rst)
    (busy_q && sw_clr) |=> !busy_out);
  // R5: an elapsed delay drops the latch when not forced
  a_r5_auto_clear: assert property (@(posedge clk) disable iff (rst)
    (busy_q && expire && !force_q) |=> !busy_out);
endmodule

// File: tb/trig_busy_gate_test.sv
module trig_busy_gate_test;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] ext_trig = '0;
  logic          wr_stb = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_stb = 1'b0;
  logic [2:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          trig_out, busy_out;

  int checks = 0;
  int errors = 0;

  trig_busy_gate #(.NUM_EXT(NE)) uut (
    .clk(clk), .rst(rst), .ext_trig(ext_trig),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
    .trig_out(trig_out), .busy_out(busy_out));

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_stb = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data;
  endtask

  task automatic count_trigs(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trig_out) c++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R9 busy", busy_out, 0);
    check("R9 trig", trig_out, 0);
    rd(3'd4, v); check("R9 count", v, 0);
    rd(3'd1, v); check("R9 ctrl", v, 0);
  endtask

  task automatic t_ext_edge();
    wr(3'd0, 32'h1);
    @(negedge clk); ext_trig[0] = 1'b1;
    @(negedge clk);
    check("R1 pulse", trig_out, 1);
    check("R1 busy set", busy_out, 1);
    @(negedge clk);
    check("R1 one clock", trig_out, 0);
    ext_trig[0] = 1'b0;
  endtask

  task automatic t_drop_and_clear();
    int c;
    @(negedge clk); ext_trig[0] = 1'b1;
    @(negedge clk); @(negedge clk); ext_trig[0] = 1'b0;
    count_trigs(3, c); check("R3 blocked", c, 0);
    wr(3'd1, 32'h1); check("R4 bit0 set keeps", busy_out, 1);
    wr(3'd1, 32'h0); check("R4 clear", busy_out, 0);
    count_trigs(4, c); check("R3 not queued", c, 0);
  endtask

  task automatic t_mask();
    int c;
    @(negedge clk); ext_trig[1] = 1'b1;
    count_trigs(4, c); check("R2 masked input", c, 0);
    ext_trig[1] = 1'b0;
  endtask

  task automatic t_cmd_and_count();
    logic [31:0] v;
    wr(3'd5, 32'h1);
    check("R2 command trigger", trig_out, 1);
    wr(3'd1, 32'h0);
    rd(3'd4, v); check("R8 count", v, 2);
    wr(3'd4, 32'h0);
    rd(3'd4, v); check("R8 reset by write", v, 0);
  endtask

  task automatic t_auto_clear();
    wr(3'd3, 32'd5);
    wr(3'd1, 32'h4);
    @(negedge clk); ext_trig[0] = 1'b1;
    @(negedge clk); ext_trig[0] = 1'b0;
    check("R5 trig", trig_out, 1);
    repeat (4) @(negedge clk);
    check("R5 held before delay", busy_out, 1);
    @(negedge clk);
    check("R5 cleared at delay", busy_out, 0);
    // restart by rewriting the delay
    @(negedge clk); ext_trig[0] = 1'b1;
    @(negedge clk); ext_trig[0] = 1'b0;
    @(negedge clk);
    wr(3'd3, 32'd5);
    repeat (4) @(negedge clk);
    check("R5 restart held", busy_out, 1);
    @(negedge clk);
    check("R5 restart cleared", busy_out, 0);
  endtask

  task automatic t_force();
    int c;
    wr(3'd1, 32'h0);
    wr(3'd1, 32'h2);
    count_trigs(4, c); check("R6 one trigger", c, 1);
    check("R6 busy", busy_out, 1);
    wr(3'd1, 32'h0); check("R6 write clear blocked", busy_out, 1);
    wr(3'd1, 32'h0); check("R4 clear after release", busy_out, 0);
    wr(3'd1, 32'h6);
    repeat (10) @(negedge clk);
    check("R6 timeout blocked", busy_out, 1);
    wr(3'd1, 32'h5);
    count_trigs(3, c); check("R6 no trigger on release", c, 0);
    check("R5 clears after release", busy_out, 0);
  endtask

  task automatic t_osc();
    int c, first, second, n;
    logic [31:0] v;
    wr(3'd3, 32'd2);
    wr(3'd1, 32'h4);
    wr(3'd2, 32'd8);
    rd(3'd2, v); check("R10 period readback", v, 8);
    wr(3'd0, 32'h8000_0000);
    first = -1; second = -1; n = 0;
    while (second < 0 && n < 60) begin
      @(negedge clk); n++;
      if (trig_out) begin
        if (first < 0) first = n; else second = n;
      end
    end
    check("R7 period", second - first, 8);
    wr(3'd0, 32'h0);
    repeat (4) @(negedge clk);
    count_trigs(20, c); check("R7 disabled", c, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ext_edge();
    t_drop_and_clear();
    t_mask();
    t_cmd_and_count();
    t_auto_clear();
    t_force();
    t_osc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule